// File: doc/BRIEF.md
# Pipelined Synchronous SRAM with Byte Writes

A single-port synchronous memory of parameterised depth whose word is four lanes of nine bits (eight data bits and one parity bit each, 36 bits in total). Every control, address and data input is sampled on the rising clock edge, and read data passes through a second register before it reaches the output. A read therefore delivers its word two edges after its address was taken. Writes may cover the whole word or any chosen set of lanes.

Each access is opened by one of two address strobes while the three chip-select inputs hold their selecting levels. After that the block may stay on the same address, or step through a four-word burst in linear or interleaved order, with no further strobe. The output is a data value with a separate drive flag that stands for the bus being driven. The flag falls when output enable is high or sleep is raised, and it stays low after a write until a new strobed read. Sleep is an asynchronous input and may only be raised while the block is deselected.

Top module: `sram_pipe_top`

## Requirements
- R1: While reset is high, and on the first cycle after it falls, `rd_drive` is 0.
- R2: A strobe opens an access only when `sel0_n`=0, `sel1`=1 and `sel2_n`=0. With any other combination the strobe deselects the block and no data is driven for it. Cycles without a strobe ignore the three select inputs.
- R3: A read whose address is taken at edge k has its word on `rd_data`, with `rd_drive`=1, after edge k+2, provided `out_en_n` is 0 and sleep stays low.
- R4: `wr_all_n`=0 writes all 36 bits, whatever `lane_wr_en_n` and `lane_stb_n` are.
- R5: `wr_all_n`=1, `lane_wr_en_n`=0 and `lane_stb_n`=4'b0000 also writes all 36 bits.
- R6: With `wr_all_n`=1 and `lane_wr_en_n`=0, only the lanes whose strobe is 0 are written. Lane i is `lane_stb_n[i]` and bits [9i+8:9i].
- R7: A cycle that writes no lane is a read and leaves the memory unchanged. This covers `wr_all_n`=1 with `lane_wr_en_n`=1, and `lane_wr_en_n`=0 with all lane strobes 1.
- R8: A cycle strobed by `astb_rd_n`=0 is always a read, whatever the write inputs are. It takes priority over `astb_n`.
- R9: In a cycle without a strobe, `step_n`=0 advances the burst count and `step_n`=1 keeps the current address. The low two address bits are (base+n) mod 4 when `seq_linear`=1 and base XOR n when it is 0. The upper bits stay at the strobed address.
- R10: After a write, reads without a strobe keep `rd_drive` at 0 until a strobed read starts.
- R11: `rd_drive` is 1 only when `out_en_n` is 0, a valid read word sits in the output register and `sleep_req` is 0. `out_en_n` acts without waiting for a clock edge.
- R12: Raising `sleep_req` drops `rd_drive` at once. Cycles presented while it is high have no effect, and after it falls `rd_drive` stays 0 until a new strobed read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| addr | input | ADDR_W | Word address, taken with a strobe |
| astb_rd_n | input | 1 | Address strobe that forces a read, active low |
| astb_n | input | 1 | Address strobe that honours the write inputs, active low |
| step_n | input | 1 | Burst advance in cycles without a strobe, active low |
| seq_linear | input | 1 | Burst order: 1 linear, 0 interleaved |
| sel0_n | input | 1 | Chip select, selects when low |
| sel1 | input | 1 | Chip select, selects when high |
| sel2_n | input | 1 | Chip select, selects when low |
| wr_all_n | input | 1 | Full-word write, active low |
| lane_wr_en_n | input | 1 | Enables the per-lane strobes, active low |
| lane_stb_n | input | 4 | Per-lane write strobes, active low |
| out_en_n | input | 1 | Asynchronous output enable, active low |
| sleep_req | input | 1 | Asynchronous sleep request, active high |
| wdata | input | 36 | Write data, four 9-bit lanes |
| rd_data | output | 36 | Output register value |
| rd_drive | output | 1 | Output is driven (not high-impedance) |

## Verification
Full-word writes are made through both routes, and partial writes use alternating and single-lane strobe masks. Each is read back with a strobed read, so a wrong lane or a missing write shows up in the bits that changed. Write-looking cycles that write nothing, and writes attempted under the forced-read strobe, are followed by reads that must return the old word. Linear and interleaved bursts start from an unaligned base and include held steps, which separates the two orders and advance from suspend. Write-then-continue sequences, deselecting strobes, toggles of output enable between edges and a sleep entry with a write attempted during sleep probe the rules for when the bus is driven.

// File: rtl/sram_pipe_pkg.sv
package sram_pipe_pkg;

    localparam int LANES  = 4;
    localparam int LANE_W = 9;
    localparam int WORD_W = LANES * LANE_W;
    localparam int SEQ_W  = 2;

    typedef enum logic [1:0] {
        CYC_IDLE = 2'd0,
        CYC_RD   = 2'd1,
        CYC_WR   = 2'd2
    } cyc_e;

    typedef struct packed {
        cyc_e              kind;
        logic [LANES-1:0]  mask;
        logic              rd_vld;
    } op_t;

    // Lanes to be written in this cycle; an empty mask means a read.
    function automatic logic [LANES-1:0] lane_mask_f(
        input logic             wr_all_n,
        input logic             lane_wr_en_n,
        input logic [LANES-1:0] lane_stb_n
    );
        logic [LANES-1:0] m;
        if (!wr_all_n)
            m = '1;
        else if (!lane_wr_en_n)
            m = ~lane_stb_n;
        else
            m = '0;
        return m;
    endfunction

    function automatic logic chip_sel_f(
        input logic s0_n,
        input logic s1,
        input logic s2_n
    );
        return (!s0_n) && s1 && (!s2_n);
    endfunction

    function automatic logic [SEQ_W-1:0] burst_seq_f(
        input logic             linear,
        input logic [SEQ_W-1:0] base,
        input logic [SEQ_W-1:0] n
    );
        return linear ? (base + n) : (base ^ n);
    endfunction

endpackage

// File: rtl/sram_burst_ctl.sv
module sram_burst_ctl
    import sram_pipe_pkg::*;
#(
    parameter int ADDR_W = 6
) (
    input  logic                clk,
    input  logic                rst,
    input  logic [ADDR_W-1:0]   addr,
    input  logic                astb_rd_n,
    input  logic                astb_n,
    input  logic                step_n,
    input  logic                seq_linear,
    input  logic                sel0_n,
    input  logic                sel1,
    input  logic                sel2_n,
    input  logic                wr_all_n,
    input  logic                lane_wr_en_n,
    input  logic [LANES-1:0]    lane_stb_n,
    input  logic                sleep_req,
    input  logic [WORD_W-1:0]   wdata,
    output op_t                 op_q,
    output logic [ADDR_W-1:0]   op_addr_q,
    output logic [WORD_W-1:0]   op_data_q
);

    localparam int HI_W = ADDR_W - SEQ_W;

    logic               active_q, active_d;
    logic               rd_ok_q, rd_ok_d;
    logic [ADDR_W-1:0]  base_q, base_d;
    logic [SEQ_W-1:0]   cnt_q, cnt_d;
    logic [LANES-1:0]   mask_in;
    logic               sel_ok;
    logic               strobe;
    op_t                op_d;
    logic [ADDR_W-1:0]  addr_d;

    assign mask_in = lane_mask_f(wr_all_n, lane_wr_en_n, lane_stb_n);
    assign sel_ok  = chip_sel_f(sel0_n, sel1, sel2_n);
    assign strobe  = !astb_rd_n || !astb_n;

    always_comb begin
        active_d = active_q;
        rd_ok_d  = rd_ok_q;
        base_d   = base_q;
        cnt_d    = cnt_q;
        op_d     = '{kind: CYC_IDLE, mask: '0, rd_vld: 1'b0};
        if (sleep_req) begin
            active_d = 1'b0;
            rd_ok_d  = 1'b0;
        end else if (strobe) begin
            if (sel_ok) begin
                active_d = 1'b1;
                base_d   = addr;
                cnt_d    = '0;
                if (!astb_rd_n || (mask_in == '0)) begin
                    op_d.kind   = CYC_RD;
                    op_d.rd_vld = 1'b1;
                    rd_ok_d     = 1'b1;
                end else begin
                    op_d.kind = CYC_WR;
                    op_d.mask = mask_in;
                    rd_ok_d   = 1'b0;
                end
            end else begin
                active_d = 1'b0;
                rd_ok_d  = 1'b0;
            end
        end else if (active_q) begin
            if (!step_n)
                cnt_d = cnt_q + 1'b1;
            if (mask_in == '0) begin
                op_d.kind   = CYC_RD;
                op_d.rd_vld = rd_ok_q;
            end else begin
                op_d.kind = CYC_WR;
                op_d.mask = mask_in;
                rd_ok_d   = 1'b0;
            end
        end
        addr_d = {base_d[ADDR_W-1 -: HI_W],
                  burst_seq_f(seq_linear, base_d[SEQ_W-1:0], cnt_d)};
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            active_q  <= 1'b0;
            rd_ok_q   <= 1'b0;
            base_q    <= '0;
            cnt_q     <= '0;
            op_q      <= '{kind: CYC_IDLE, mask: '0, rd_vld: 1'b0};
            op_addr_q <= '0;
            op_data_q <= '0;
        end else begin
            active_q  <= active_d;
            rd_ok_q   <= rd_ok_d;
            base_q    <= base_d;
            cnt_q     <= cnt_d;
            op_q      <= op_d;
            op_addr_q <= addr_d;
            op_data_q <= wdata;
        end
    end

endmodule

// File: rtl/sram_lane_array.sv
module sram_lane_array
    import sram_pipe_pkg::*;
#(
    parameter int ADDR_W = 6
) (
    input  logic                clk,
    input  logic [ADDR_W-1:0]   addr,
    input  logic [LANES-1:0]    wr_mask,
    input  logic [WORD_W-1:0]   wdata,
    output logic [WORD_W-1:0]   rdata
);

    localparam int DEPTH = 1 << ADDR_W;

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        logic [LANE_W-1:0] cells [DEPTH];
        logic [LANE_W-1:0] lane_q;

        always_ff @(posedge clk) begin
            if (wr_mask[g])
                cells[addr] <= wdata[g*LANE_W +: LANE_W];
            lane_q <= cells[addr];
        end

        assign rdata[g*LANE_W +: LANE_W] = lane_q;
    end

endmodule

// File: rtl/sram_out_stage.sv
module sram_out_stage
    import sram_pipe_pkg::*;
(
    input  logic                clk,
    input  logic                rst,
    input  logic                sleep_req,
    input  logic                out_en_n,
    input  logic                rd_vld_in,
    input  logic [WORD_W-1:0]   arr_data,
    output logic [WORD_W-1:0]   rd_data,
    output logic                rd_drive
);

    logic s1_vld_q;
    logic out_vld_q;
    logic [WORD_W-1:0] out_q;

    always_ff @(posedge clk) begin
        if (rst || sleep_req) begin
            s1_vld_q  <= 1'b0;
            out_vld_q <= 1'b0;
        end else begin
            s1_vld_q  <= rd_vld_in;
            out_vld_q <= s1_vld_q;
        end
    end

    always_ff @(posedge clk) begin
        if (rst)
            out_q <= '0;
        else
            out_q <= arr_data;
    end

    assign rd_data  = out_q;
    assign rd_drive = out_vld_q && !out_en_n && !sleep_req;

endmodule

// File: rtl/sram_pipe_top.sv
module sram_pipe_top
    import sram_pipe_pkg::*;
#(
    parameter int ADDR_W = 6
) (
    input  logic                clk,
    input  logic                rst,
    input  logic [ADDR_W-1:0]   addr,
    input  logic                astb_rd_n,
    input  logic                astb_n,
    input  logic                step_n,
    input  logic                seq_linear,
    input  logic                sel0_n,
    input  logic                sel1,
    input  logic                sel2_n,
    input  logic                wr_all_n,
    input  logic                lane_wr_en_n,
    input  logic [3:0]          lane_stb_n,
    input  logic                out_en_n,
    input  logic                sleep_req,
    input  logic [35:0]         wdata,
    output logic [35:0]         rd_data,
    output logic                rd_drive
);

    op_t                op;
    logic [ADDR_W-1:0]  op_addr;
    logic [WORD_W-1:0]  op_data;
    logic [WORD_W-1:0]  arr_data;
    logic [LANES-1:0]   wr_mask;

    assign wr_mask = (op.kind == CYC_WR) ? op.mask : '0;

    sram_burst_ctl #(.ADDR_W(ADDR_W)) u_ctl (
        .clk          (clk),
        .rst          (rst),
        .addr         (addr),
        .astb_rd_n    (astb_rd_n),
        .astb_n       (astb_n),
        .step_n       (step_n),
        .seq_linear   (seq_linear),
        .sel0_n       (sel0_n),
        .sel1         (sel1),
        .sel2_n       (sel2_n),
        .wr_all_n     (wr_all_n),
        .lane_wr_en_n (lane_wr_en_n),
        .lane_stb_n   (lane_stb_n),
        .sleep_req    (sleep_req),
        .wdata        (wdata),
        .op_q         (op),
        .op_addr_q    (op_addr),
        .op_data_q    (op_data)
    );

    sram_lane_array #(.ADDR_W(ADDR_W)) u_arr (
        .clk     (clk),
        .addr    (op_addr),
        .wr_mask (wr_mask),
        .wdata   (op_data),
        .rdata   (arr_data)
    );

    sram_out_stage u_out (
        .clk       (clk),
        .rst       (rst),
        .sleep_req (sleep_req),
        .out_en_n  (out_en_n),
        .rd_vld_in (op.rd_vld),
        .arr_data  (arr_data),
        .rd_data   (rd_data),
        .rd_drive  (rd_drive)
    );

endmodule

// File: rtl/sram_pipe_chk.sv
module sram_pipe_chk
    import sram_pipe_pkg::*;
(
    input logic clk,
    input logic rst,
    input logic astb_rd_n,
    input logic astb_n,
    input logic sel0_n,
    input logic sel1,
    input logic sel2_n,
    input logic out_en_n,
    input logic sleep_req,
    input logic rd_drive,
    input cyc_e op_kind
);

    logic strobe;
    logic sel_ok;
    assign strobe = !astb_rd_n || !astb_n;
    assign sel_ok = !sel0_n && sel1 && !sel2_n;

    // R1
    reset_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        $fell(rst) |-> !rd_drive);

    // R2
    deselect_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        (strobe && !sel_ok && !sleep_req) |=> ##2 !rd_drive);

    // R3
    read_latency_chk: assert property (@(posedge clk) disable iff (rst)
        (!astb_rd_n && sel_ok && !sleep_req) ##1 !sleep_req ##1 !sleep_req
        ##1 (!out_en_n && !sleep_req) |-> rd_drive);

    // R10
    write_slot_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        (op_kind == CYC_WR) |=> ##1 !rd_drive);

    // R11
    drive_gate_chk: assert property (@(posedge clk) disable iff (rst)
        rd_drive |-> (!out_en_n && !sleep_req));

    // R12
    sleep_exit_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        $fell(sleep_req) |-> !rd_drive);

endmodule

bind sram_pipe_top sram_pipe_chk u_chk (
    .clk       (clk),
    .rst       (rst),
    .astb_rd_n (astb_rd_n),
    .astb_n    (astb_n),
    .sel0_n    (sel0_n),
    .sel1      (sel1),
    .sel2_n    (sel2_n),
    .out_en_n  (out_en_n),
    .sleep_req (sleep_req),
    .rd_drive  (rd_drive),
    .op_kind   (op.kind)
);

// File: tb/sram_pipe_tb.sv
`timescale 1ns/1ps
module sram_pipe_top_tb_top;

    localparam int AW = 6;

    logic          clk = 1'b0;
    logic          rst;
    logic [AW-1:0] addr;
    logic          astb_rd_n, astb_n, step_n, seq_linear;
    logic          sel0_n, sel1, sel2_n;
    logic          wr_all_n, lane_wr_en_n;
    logic [3:0]    lane_stb_n;
    logic          out_en_n, sleep_req;
    logic [35:0]   wdata;
    logic [35:0]   rd_data;
    logic          rd_drive;

    int total = 0;
    int bad   = 0;
    bit done  = 0;
    string tag = "R1";

    // behavioural reference state
    logic [35:0] mm [64];
    bit          e_vld [3];
    logic [35:0] e_dat [3];
    bit          m_active, m_rdok;
    int          m_base, m_n;

    always #2.5 clk = ~clk;

    sram_pipe_top #(.ADDR_W(AW)) dut_i (
        .clk(clk), .rst(rst), .addr(addr), .astb_rd_n(astb_rd_n), .astb_n(astb_n),
        .step_n(step_n), .seq_linear(seq_linear), .sel0_n(sel0_n), .sel1(sel1),
        .sel2_n(sel2_n), .wr_all_n(wr_all_n), .lane_wr_en_n(lane_wr_en_n),
        .lane_stb_n(lane_stb_n), .out_en_n(out_en_n), .sleep_req(sleep_req),
        .wdata(wdata), .rd_data(rd_data), .rd_drive(rd_drive)
    );

    task automatic chk(input string t, input bit ok, input logic [35:0] act, input logic [35:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s act=%h exp=%h at %0t", t, act, exp, $time);
        end
    endtask

    task automatic model_edge();
        logic [3:0] m;
        bit strobe, selok, acc, is_rd, vld;
        int lo, a;
        if (rst) begin
            for (int i = 0; i < 3; i++) e_vld[i] = 0;
            m_active = 0; m_rdok = 0; m_base = 0; m_n = 0;
            return;
        end
        if (sleep_req) begin
            for (int i = 0; i < 3; i++) e_vld[i] = 0;
            m_active = 0; m_rdok = 0;
            return;
        end
        e_vld[2] = e_vld[1]; e_dat[2] = e_dat[1];
        e_vld[1] = e_vld[0]; e_dat[1] = e_dat[0];
        e_vld[0] = 0;
        for (int i = 0; i < 4; i++)
            m[i] = !wr_all_n || (!lane_wr_en_n && !lane_stb_n[i]);
        strobe = !astb_rd_n || !astb_n;
        selok  = !sel0_n && sel1 && !sel2_n;
        acc = 0; is_rd = 0; vld = 0;
        if (strobe) begin
            if (selok) begin
                m_active = 1; m_base = int'(addr); m_n = 0; acc = 1;
                if (!astb_rd_n || m == 4'b0) begin
                    is_rd = 1; vld = 1; m_rdok = 1;
                end else m_rdok = 0;
            end else begin
                m_active = 0; m_rdok = 0;
            end
        end else if (m_active) begin
            if (!step_n) m_n++;
            acc = 1;
            if (m == 4'b0) begin
                is_rd = 1; vld = m_rdok;
            end else m_rdok = 0;
        end
        if (acc) begin
            if (seq_linear) lo = ((m_base % 4) + m_n) % 4;
            else            lo = (m_base % 4) ^ (m_n % 4);
            a = (m_base / 4) * 4 + lo;
            if (is_rd) begin
                e_vld[0] = vld; e_dat[0] = mm[a];
            end else begin
                for (int i = 0; i < 4; i++)
                    if (m[i]) mm[a][i*9 +: 9] = wdata[i*9 +: 9];
            end
        end
    endtask

    task automatic compare();
        bit ed;
        ed = e_vld[2] && !out_en_n && !sleep_req;
        chk({tag, " drive"}, rd_drive == ed, {35'b0, rd_drive}, {35'b0, ed});
        if (ed) chk({tag, " data"}, rd_data == e_dat[2], rd_data, e_dat[2]);
    endtask

    task automatic tick();
        @(posedge clk);
        model_edge();
        @(negedge clk);
        compare();
    endtask

    task automatic idle_in();
        astb_rd_n = 1; astb_n = 1; step_n = 1;
        wr_all_n = 1; lane_wr_en_n = 1; lane_stb_n = 4'hF;
    endtask

    task automatic wr_full(input int a, input logic [35:0] d);
        idle_in(); astb_n = 0; addr = AW'(a); wr_all_n = 0; lane_stb_n = 4'h5; wdata = d;
        tick(); idle_in();
    endtask

    task automatic rd_str(input int a);
        idle_in(); astb_rd_n = 0; addr = AW'(a);
        tick(); idle_in();
    endtask

    task automatic flush(input int n);
        for (int i = 0; i < n; i++) tick();
    endtask

    initial begin
        #(200000 * 5);
        if (!done) begin
            total++; bad++;
            $display("FAIL watchdog expired");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        for (int i = 0; i < 64; i++) mm[i] = '0;
        rst = 1; addr = '0; seq_linear = 1; sel0_n = 0; sel1 = 1; sel2_n = 0;
        out_en_n = 0; sleep_req = 0; wdata = '0;
        idle_in();
        // R1: reset state and the first cycle after release
        tag = "R1";
        flush(3);
        rst = 0;
        tick();
        chk("R1 post-reset drive", rd_drive == 1'b0, {35'b0, rd_drive}, 36'b0);

        // preload words so every read below hits a known value
        tag = "R4";
        for (int i = 0; i < 24; i++) wr_full(i, {4'(i), 32'hA5C3_0000 + 32'(i * 17)});
        flush(3);
        // R4: full write with lane strobes at an arbitrary pattern, read back
        tag = "R3";
        for (int i = 0; i < 8; i++) begin rd_str(i); flush(2); end
        flush(3);

        // R5: full write via lane enable with all lane strobes low
        tag = "R5";
        idle_in(); astb_n = 0; addr = 6'd9; lane_wr_en_n = 0; lane_stb_n = 4'h0;
        wdata = 36'h9_1234_5678; tick(); idle_in();
        rd_str(9); flush(4);

        // R6: partial writes, alternating and single-lane masks
        tag = "R6";
        idle_in(); astb_n = 0; addr = 6'd10; lane_wr_en_n = 0; lane_stb_n = 4'b1010;
        wdata = 36'hF_FFFF_FFFF; tick(); idle_in();
        rd_str(10); flush(4);
        idle_in(); astb_n = 0; addr = 6'd11; lane_wr_en_n = 0; lane_stb_n = 4'b0111;
        wdata = 36'h0_0000_0000; tick(); idle_in();
        rd_str(11); flush(4);

        // R7: write-looking cycles that write nothing are reads
        tag = "R7";
        idle_in(); astb_n = 0; addr = 6'd12; lane_wr_en_n = 1; lane_stb_n = 4'h0;
        wdata = 36'h1_1111_1111; tick(); idle_in();
        flush(3);
        idle_in(); astb_n = 0; addr = 6'd13; lane_wr_en_n = 0; lane_stb_n = 4'hF;
        wdata = 36'h2_2222_2222; tick(); idle_in();
        rd_str(12); flush(2); rd_str(13); flush(4);

        // R8: forced-read strobe ignores the write inputs
        tag = "R8";
        idle_in(); astb_rd_n = 0; astb_n = 0; addr = 6'd14; wr_all_n = 0;
        wdata = 36'h3_3333_3333; tick(); idle_in();
        flush(3);
        rd_str(14); flush(4);

        // R9: linear burst from unaligned base 5 with one held step
        tag = "R9";
        seq_linear = 1;
        rd_str(5);
        step_n = 0; tick(); tick(); step_n = 1; tick(); step_n = 0; tick(); idle_in();
        flush(3);
        // R9: interleaved burst from base 6
        seq_linear = 0;
        rd_str(6);
        step_n = 0; tick(); tick(); tick(); idle_in();
        flush(3);
        // R9: interleaved burst write from base 17, then read back
        idle_in(); astb_n = 0; addr = 6'd17; wr_all_n = 0; wdata = 36'hB_0000_0001; tick();
        astb_n = 1; step_n = 0; wdata = 36'hB_0000_0002; tick();
        wdata = 36'hB_0000_0003; tick(); idle_in();
        seq_linear = 1;
        for (int i = 16; i < 20; i++) begin rd_str(i); flush(1); end
        flush(3);

        // R10: continuation reads after a write stay undriven
        tag = "R10";
        wr_full(20, 36'hC_CCCC_0014);
        step_n = 0; tick(); tick(); step_n = 1; tick(); tick();
        chk("R10 cont read after write", rd_drive == 1'b0, {35'b0, rd_drive}, 36'b0);
        rd_str(20); flush(3);
        chk("R10 strobed read restores drive", rd_drive == 1'b1, {35'b0, rd_drive}, 36'b1);
        idle_in();

        // R2: deselecting select patterns on a strobe
        tag = "R2";
        sel0_n = 1; rd_str(1); flush(3);
        sel0_n = 0; sel1 = 0; rd_str(1); flush(3);
        sel1 = 1; sel2_n = 1; rd_str(1); flush(3);
        chk("R2 deselected read", rd_drive == 1'b0, {35'b0, rd_drive}, 36'b0);
        sel2_n = 0;
        // R2: continuation ignores the selects
        rd_str(2);
        sel1 = 0; step_n = 0; tick(); tick(); step_n = 1; tick(); tick();
        chk("R2 continuation ignores selects", rd_drive == 1'b1, {35'b0, rd_drive}, 36'b1);
        sel1 = 1; idle_in();

        // R11: output enable acts between edges
        tag = "R11";
        out_en_n = 1; #0.5;
        chk("R11 oe high drops drive", rd_drive == 1'b0, {35'b0, rd_drive}, 36'b0);
        out_en_n = 0; #0.5;
        chk("R11 oe low restores drive", rd_drive == 1'b1, {35'b0, rd_drive}, 36'b1);
        tick();

        // R12: sleep entry while deselected, write attempt during sleep
        tag = "R12";
        rd_str(4);
        idle_in(); astb_n = 0; sel1 = 0; tick(); idle_in(); sel1 = 1;
        sleep_req = 1; #0.5;
        chk("R12 sleep drops drive", rd_drive == 1'b0, {35'b0, rd_drive}, 36'b0);
        tick();
        idle_in(); astb_n = 0; addr = 6'd4; wr_all_n = 0; wdata = 36'hD_DEAD_BEEF; tick(); idle_in();
        tick();
        sleep_req = 0;
        tick(); tick(); tick();
        chk("R12 undriven after sleep", rd_drive == 1'b0, {35'b0, rd_drive}, 36'b0);
        rd_str(4); flush(3);
        chk("R12 word kept over sleep", rd_data == mm[4], rd_data, mm[4]);
        flush(2);

        done = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule